// File: doc/BRIEF.md
# Buffer Memory Self-Test Fill Engine

This block fills every byte of an 8 KB buffer memory with a generated pattern and folds the bytes it writes into a 16-bit checksum. Software can then compare that checksum with a value it computes itself, which shows whether the memory and the fill logic behave as intended. There are three fill sources: an 8-bit LFSR started from a seed, the low byte of each address, and a seed byte that is rotated left by a programmable amount after every write. A host programs the engine through four byte registers. The engine writes through one of two memory write ports. The other port carries the traffic of a DMA engine, and a control bit chooses which of the two ports the engine uses.

A host writes the seed first. It then writes the control register with the enable and start bits set. While the test runs, the start bit reads back as busy. When it reads 0 again, the checksum registers hold the result. The memory itself is outside the block.

The controller is a three-state machine:
- `S_IDLE` waits for a start request that is allowed to proceed. It then moves to `S_LOAD`.
- `S_LOAD` lasts one cycle. It loads the pattern register from the seed, clears the checksum and clears the address counter, then moves to `S_FILL`.
- `S_FILL` makes one memory write per cycle at ascending addresses. After the write to the last address it moves back to `S_IDLE`.

Top module: `membist_top`

## Requirements
- R1: After reset, the control, seed and both checksum registers read 0, and the engine drives no memory write on either port.
- R2: A start request is accepted when all of the following hold: the engine is idle, the written byte has bit 0 (start) and bit 1 (enable) set, and the mode field is not 11. The start bit then reads 1 from the next cycle, stays 1 for exactly 8193 cycles, and then reads 0.
- R3: During a test the engine writes addresses 0 to 8191 exactly once each, in ascending order, one per cycle, starting two cycles after the accepted start write.
- R4: Mode 00 (control bits 3:2) writes the output of an 8-bit LFSR. The LFSR shifts left and feeds bit 7 XOR bit 5 XOR bit 4 XOR bit 3 into bit 0. It starts from the seed and advances after each write. A seed of 0 is replaced by 0x01.
- R5: Mode 01 writes the low 8 bits of the address at each location.
- R6: Mode 10 writes the seed at address 0. After each write the byte is rotated left by the value of control bits 7:5. The rotate amount has no effect in the other modes.
- R7: The checksum is the end-around-carry (ones-complement) sum of the written bytes taken as 16-bit words. Even addresses supply the high byte and odd addresses the low byte. The checksum is cleared when a test starts. Register 2 returns its low byte and register 3 its high byte.
- R8: A start request is ignored if the enable bit is clear, if mode 11 is selected, or if any of the DMA-active, receive-enable or transmit-pending inputs is high. After an ignored request, busy stays 0, no memory write occurs and the checksum keeps its value.
- R9: With control bit 4 clear, the engine uses port A and the DMA engine's write passes through on port B. With bit 4 set, the two are swapped.
- R10: Writes to the control or seed register while busy have no effect. The checksum registers cannot be written.
- R11: Register addresses are 0 for control (bits 7:5 rotate amount, bit 4 port swap, bits 3:2 mode, bit 1 enable, bit 0 start/busy), 1 for seed, 2 for checksum low and 3 for checksum high. Reads return data in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dma_active | input | 1 | DMA transfer in progress; blocks a start |
| rx_enabled | input | 1 | Packet reception enabled; blocks a start |
| tx_pending | input | 1 | Transmission requested; blocks a start |
| dma_we | input | 1 | DMA engine write enable |
| dma_addr | input | 13 | DMA engine write address |
| dma_wdata | input | 8 | DMA engine write data |
| mem_a_we | output | 1 | Memory port A write enable |
| mem_a_addr | output | 13 | Memory port A address |
| mem_a_wdata | output | 8 | Memory port A write data |
| mem_b_we | output | 1 | Memory port B write enable |
| mem_b_addr | output | 13 | Memory port B address |
| mem_b_wdata | output | 8 | Memory port B write data |

## Verification
A start write taken at a clock edge makes busy readable in the same sampling slot, half a cycle later, while the engine is in its load cycle. The write to address i appears on the selected port i+1 cycles after that edge, and busy and the final checksum are both due 8193 cycles after it. The bench drives every input on the falling edge and samples the outputs shortly afterwards. It follows the engine one cycle at a time: one sample in the load cycle, one per write, then one read of the result in the first idle cycle. Requests that should be ignored are checked over the next several cycles for busy, for writes on both ports and for an unchanged checksum.

// File: rtl/membist_pkg.sv
package membist_pkg;
    localparam int BYTE_W  = 8;
    localparam int CKSUM_W = 16;
    localparam int ROT_W   = 3;
    localparam int REG_AW  = 2;

    typedef enum logic [1:0] {
        FILL_LFSR  = 2'b00,
        FILL_ADDR  = 2'b01,
        FILL_ROT   = 2'b10,
        FILL_RSVD  = 2'b11
    } fill_mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOAD = 2'd1,
        S_FILL = 2'd2
    } bist_state_e;

    // control byte bits 7:1 (bit 0 is the start/busy bit)
    typedef struct packed {
        logic [ROT_W-1:0] rot_amt;
        logic             swap;
        fill_mode_e       mode;
        logic             enable;
    } ctrl_t;

    localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] RA_SEED = 2'd1;
    localparam logic [REG_AW-1:0] RA_CKLO = 2'd2;
    localparam logic [REG_AW-1:0] RA_CKHI = 2'd3;
endpackage

// File: rtl/membist_regs.sv
module membist_regs
    import membist_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    input  logic                 busy,
    input  logic [CKSUM_W-1:0]   cksum,
    output logic [BYTE_W-1:0]    reg_rdata,
    output ctrl_t                ctrl,
    output logic [BYTE_W-1:0]    seed,
    output logic                 start_req,
    output ctrl_t                req_ctrl
);
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] seed_q;
    logic              wr_ctrl, wr_seed;

    assign wr_ctrl   = reg_we && (reg_addr == RA_CTRL) && !busy;
    assign wr_seed   = reg_we && (reg_addr == RA_SEED) && !busy;
    assign req_ctrl  = ctrl_t'(reg_wdata[BYTE_W-1:1]);
    assign start_req = wr_ctrl && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            seed_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= req_ctrl;
            if (wr_seed) seed_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {ctrl_q, busy};
            RA_SEED: reg_rdata = seed_q;
            RA_CKLO: reg_rdata = cksum[BYTE_W-1:0];
            RA_CKHI: reg_rdata = cksum[CKSUM_W-1:BYTE_W];
            default: reg_rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;
    assign seed = seed_q;

    assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ctrl_q) && $stable(seed_q)));
endmodule

// File: rtl/membist_pattern.sv
module membist_pattern
    import membist_pkg::*;
#(
    parameter int ADDR_W = 13
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  fill_mode_e           mode,
    input  logic [ROT_W-1:0]     rot_amt,
    input  logic [BYTE_W-1:0]    seed,
    input  logic [ADDR_W-1:0]    addr,
    output logic [BYTE_W-1:0]    data
);
    logic [BYTE_W-1:0] pat_q;

    function automatic logic [BYTE_W-1:0] lfsr_adv(input logic [BYTE_W-1:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    function automatic logic [BYTE_W-1:0] rotl(input logic [BYTE_W-1:0] v,
                                               input logic [ROT_W-1:0] n);
        logic [2*BYTE_W-1:0] dbl;
        dbl = {v, v} << n;
        return dbl[2*BYTE_W-1:BYTE_W];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= '0;
        end else if (load) begin
            if (mode == FILL_LFSR && seed == '0) pat_q <= 8'h01;
            else                                 pat_q <= seed;
        end else if (step) begin
            unique case (mode)
                FILL_LFSR: pat_q <= lfsr_adv(pat_q);
                FILL_ROT:  pat_q <= rotl(pat_q, rot_amt);
                default:   pat_q <= pat_q;
            endcase
        end
    end

    generate
        if (ADDR_W >= BYTE_W) begin : g_wide
            assign data = (mode == FILL_ADDR) ? addr[BYTE_W-1:0] : pat_q;
        end else begin : g_narrow
            assign data = (mode == FILL_ADDR) ? {{(BYTE_W-ADDR_W){1'b0}}, addr} : pat_q;
        end
    endgenerate

    assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && mode == FILL_LFSR) |-> (pat_q != '0));
endmodule

// File: rtl/membist_cksum.sv
module membist_cksum
    import membist_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 add,
    input  logic                 high_lane,
    input  logic [BYTE_W-1:0]    din,
    output logic [CKSUM_W-1:0]   sum
);
    logic [CKSUM_W-1:0] acc_q;
    logic [CKSUM_W-1:0] word;
    logic [CKSUM_W:0]   raw;
    logic [CKSUM_W-1:0] folded;

    always_comb begin
        word   = high_lane ? {din, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, din};
        raw    = {1'b0, acc_q} + {1'b0, word};
        folded = raw[CKSUM_W-1:0] + {{(CKSUM_W-1){1'b0}}, raw[CKSUM_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc_q <= '0;
        else if (clear) acc_q <= '0;
        else if (add)   acc_q <= folded;
    end

    assign sum = acc_q;

    assert_cksum_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (acc_q == '0));
    assert_cksum_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clear) && !$past(add)) |-> $stable(acc_q));
endmodule

// File: rtl/membist_portmux.sv
module membist_portmux
    import membist_pkg::*;
#(
    parameter int ADDR_W = 13
)(
    input  logic                 swap,
    input  logic                 bist_we,
    input  logic [ADDR_W-1:0]    bist_addr,
    input  logic [BYTE_W-1:0]    bist_wdata,
    input  logic                 dma_we,
    input  logic [ADDR_W-1:0]    dma_addr,
    input  logic [BYTE_W-1:0]    dma_wdata,
    output logic [1:0]           port_we,
    output logic [ADDR_W-1:0]    port_addr  [2],
    output logic [BYTE_W-1:0]    port_wdata [2]
);
    genvar p;
    generate
        for (p = 0; p < 2; p++) begin : g_port
            logic use_bist;
            assign use_bist      = (swap == (p == 1));
            assign port_we[p]    = use_bist ? bist_we    : dma_we;
            assign port_addr[p]  = use_bist ? bist_addr  : dma_addr;
            assign port_wdata[p] = use_bist ? bist_wdata : dma_wdata;
        end
    endgenerate
endmodule

// File: rtl/membist_top.sv
module membist_top
    import membist_pkg::*;
#(
    parameter int ADDR_W = 13
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 dma_active,
    input  logic                 rx_enabled,
    input  logic                 tx_pending,
    input  logic                 dma_we,
    input  logic [ADDR_W-1:0]    dma_addr,
    input  logic [7:0]           dma_wdata,
    output logic                 mem_a_we,
    output logic [ADDR_W-1:0]    mem_a_addr,
    output logic [7:0]           mem_a_wdata,
    output logic                 mem_b_we,
    output logic [ADDR_W-1:0]    mem_b_addr,
    output logic [7:0]           mem_b_wdata
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    bist_state_e        state_q, state_d;
    logic [ADDR_W-1:0]  cnt_q;
    ctrl_t              ctrl, req_ctrl;
    logic [BYTE_W-1:0]  seed, fill_byte;
    logic [CKSUM_W-1:0] cksum;
    logic               start_req, accept, busy;
    logic               do_load, do_write;
    logic [1:0]         port_we;
    logic [ADDR_W-1:0]  port_addr  [2];
    logic [BYTE_W-1:0]  port_wdata [2];

    assign busy   = (state_q != S_IDLE);
    assign accept = start_req && req_ctrl.enable && (req_ctrl.mode != FILL_RSVD)
                    && !dma_active && !rx_enabled && !tx_pending;

    membist_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .cksum(cksum), .reg_rdata(reg_rdata),
        .ctrl(ctrl), .seed(seed), .start_req(start_req), .req_ctrl(req_ctrl)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (do_load)       cnt_q <= '0;
            else if (do_write) cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_LOAD;
            S_LOAD: state_d = S_FILL;
            S_FILL: if (cnt_q == LAST_ADDR) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        do_load  = 1'b0;
        do_write = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_LOAD: do_load  = 1'b1;
            S_FILL: do_write = 1'b1;
            default: ;
        endcase
    end

    membist_pattern #(.ADDR_W(ADDR_W)) u_pat (
        .clk(clk), .rst_n(rst_n), .load(do_load), .step(do_write),
        .mode(ctrl.mode), .rot_amt(ctrl.rot_amt), .seed(seed),
        .addr(cnt_q), .data(fill_byte)
    );

    membist_cksum u_ck (
        .clk(clk), .rst_n(rst_n), .clear(do_load), .add(do_write),
        .high_lane(~cnt_q[0]), .din(fill_byte), .sum(cksum)
    );

    membist_portmux #(.ADDR_W(ADDR_W)) u_mux (
        .swap(ctrl.swap), .bist_we(do_write), .bist_addr(cnt_q), .bist_wdata(fill_byte),
        .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .port_we(port_we), .port_addr(port_addr), .port_wdata(port_wdata)
    );

    assign mem_a_we    = port_we[0];
    assign mem_a_addr  = port_addr[0];
    assign mem_a_wdata = port_wdata[0];
    assign mem_b_we    = port_we[1];
    assign mem_b_addr  = port_addr[1];
    assign mem_b_wdata = port_wdata[1];

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && accept) |=> (state_q == S_LOAD));
    assert_reserved_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_req && req_ctrl.mode == FILL_RSVD) |=> (state_q == S_IDLE));
    assert_blocked_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && (dma_active || rx_enabled || tx_pending)) |=> (state_q == S_IDLE));
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && $past(state_q) == S_FILL) |-> (cnt_q == $past(cnt_q) + 1'b1));
    assert_fill_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && $past(state_q) == S_LOAD) |-> (cnt_q == '0));
endmodule

// File: tb/sim_membist_top.sv
module sim_membist_top;
    localparam int AW = 13;
    localparam int NLOC = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic dma_active = 1'b0, rx_enabled = 1'b0, tx_pending = 1'b0;
    logic dma_we = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic [7:0] dma_wdata = 8'd0;
    logic mem_a_we, mem_b_we;
    logic [AW-1:0] mem_a_addr, mem_b_addr;
    logic [7:0] mem_a_wdata, mem_b_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    membist_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_active(dma_active),
        .rx_enabled(rx_enabled), .tx_pending(tx_pending), .dma_we(dma_we),
        .dma_addr(dma_addr), .dma_wdata(dma_wdata), .mem_a_we(mem_a_we),
        .mem_a_addr(mem_a_addr), .mem_a_wdata(mem_a_wdata), .mem_b_we(mem_b_we),
        .mem_b_addr(mem_b_addr), .mem_b_wdata(mem_b_wdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lfsr_nx(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    function automatic logic [7:0] rot_left(input logic [7:0] v, input int n);
        logic [7:0] r;
        r = v;
        for (int k = 0; k < n; k++) r = {r[6:0], r[7]};
        return r;
    endfunction

    function automatic logic [15:0] ck_add(input logic [15:0] acc, input logic [7:0] b, input int a);
        logic [16:0] s;
        s = {1'b0, acc} + ((a % 2 == 0) ? {9'd0, b} << 8 : {9'd0, b});
        return s[15:0] + {15'd0, s[16]};
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Runs one full test and checks every write plus the result.
    task automatic run_test(input logic [1:0] mode, input logic [7:0] seed,
                            input int rot, input bit swap, input bit poke_busy);
        logic [7:0] ctl, pat, exp_b, rd, lo, hi;
        logic [15:0] ck;
        int bad_addr, bad_data, bad_dma, bad_busy;
        bit bw;
        logic [AW-1:0] ba;
        logic [7:0] bd;
        ctl = {rot[2:0], swap, mode, 1'b1, 1'b1};
        reg_write(2'd1, seed);
        reg_write(2'd0, ctl);
        reg_read(2'd0, rd);
        check(rd[0] == 1'b1, "R2 busy set after start", rd, 1);
        check(!mem_a_we && !mem_b_we, "R3 no write in load cycle", {mem_a_we, mem_b_we}, 0);
        pat = (mode == 2'b00 && seed == 8'd0) ? 8'h01 : seed;
        ck = 16'd0;
        bad_addr = 0; bad_data = 0; bad_dma = 0; bad_busy = 0;
        for (int i = 0; i < NLOC; i++) begin
            @(negedge clk);
            dma_we = 1'b1;
            dma_addr = AW'($urandom);
            dma_wdata = 8'($urandom);
            if (poke_busy && i == 50) begin
                reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = ctl ^ 8'hF4;
            end else if (poke_busy && i == 51) begin
                reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = ~seed;
            end else if (poke_busy && i == 52) begin
                reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h5A;
            end else begin
                reg_we = 1'b0; reg_addr = 2'd0;
            end
            #1;
            if (swap) begin
                bw = mem_b_we; ba = mem_b_addr; bd = mem_b_wdata;
                if (!(mem_a_we && mem_a_addr == dma_addr && mem_a_wdata == dma_wdata)) bad_dma++;
            end else begin
                bw = mem_a_we; ba = mem_a_addr; bd = mem_a_wdata;
                if (!(mem_b_we && mem_b_addr == dma_addr && mem_b_wdata == dma_wdata)) bad_dma++;
            end
            exp_b = (mode == 2'b01) ? 8'(i) : pat;
            if (!bw || ba != AW'(i)) bad_addr++;
            if (bd != exp_b) begin
                if (bad_data == 0)
                    $display("FAIL R4/R5/R6 first data miss at %0d actual=0x%0h expected=0x%0h", i, bd, exp_b);
                bad_data++;
            end
            if (!(reg_addr == 2'd0 && reg_rdata[0] == 1'b1) && reg_addr == 2'd0) bad_busy++;
            ck = ck_add(ck, exp_b, i);
            if (mode == 2'b00) pat = lfsr_nx(pat);
            else if (mode == 2'b10) pat = rot_left(pat, rot);
        end
        @(negedge clk);
        reg_we = 1'b0;
        dma_we = 1'b0;
        #1;
        check(bad_addr == 0, "R3 address sequence", bad_addr, 0);
        if (mode == 2'b00)      check(bad_data == 0, "R4 lfsr data", bad_data, 0);
        else if (mode == 2'b01) check(bad_data == 0, "R5 address data", bad_data, 0);
        else                    check(bad_data == 0, "R6 rotate data", bad_data, 0);
        check(bad_dma == 0, "R9 dma pass-through on other port", bad_dma, 0);
        check(bad_busy == 0, "R2 busy held during fill", bad_busy, 0);
        check(!mem_a_we && !mem_b_we, "R3 no write after last address", {mem_a_we, mem_b_we}, 0);
        reg_read(2'd0, rd);
        check(rd == {ctl[7:1], 1'b0}, "R2 R10 control after run, busy clear", rd, {ctl[7:1], 1'b0});
        reg_read(2'd1, rd);
        check(rd == seed, "R10 seed unchanged", rd, seed);
        reg_read(2'd2, lo);
        reg_read(2'd3, hi);
        check({hi, lo} == ck, "R7 checksum", {hi, lo}, ck);
    endtask

    // Start request that must be ignored.
    task automatic try_blocked(input logic [7:0] ctl, input logic [2:0] inh, input string tag);
        logic [7:0] lo0, hi0, lo1, hi1, rd;
        int bad;
        reg_read(2'd2, lo0);
        reg_read(2'd3, hi0);
        {dma_active, rx_enabled, tx_pending} = inh;
        reg_write(2'd0, ctl);
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            reg_read(2'd0, rd);
            if (rd[0] || mem_a_we || mem_b_we) bad++;
            @(negedge clk);
        end
        {dma_active, rx_enabled, tx_pending} = 3'b000;
        reg_read(2'd2, lo1);
        reg_read(2'd3, hi1);
        check(bad == 0, tag, bad, 0);
        check({hi1, lo1} == {hi0, lo0}, "R8 checksum kept after ignored start", {hi1, lo1}, {hi0, lo0});
    endtask

    initial begin
        #700000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), rd);
            check(rd == 8'd0, "R1 R11 register reset value", rd, 0);
        end
        check(!mem_a_we && !mem_b_we, "R1 no write in reset", {mem_a_we, mem_b_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(2'd0, rd);
        check(rd == 8'd0, "R1 control after reset release", rd, 0);

        // directed corners
        run_test(2'b00, 8'h00, 0, 1'b0, 1'b0);               // R4 zero seed
        run_test(2'b01, 8'h3C, 5, 1'b1, 1'b0);               // R5 rotate ignored, R9 swap
        run_test(2'b10, 8'h01, 0, 1'b0, 1'b1);               // R6 zero rotate, R10 busy writes
        // constrained random
        for (int r = 0; r < 4; r++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 2));
            run_test(m, 8'($urandom), int'($urandom_range(0, 7)), 1'($urandom), r == 1);
        end

        // R8 ignored starts
        try_blocked(8'b000_0_00_0_1, 3'b000, "R8 start without enable");
        try_blocked(8'b000_0_11_1_1, 3'b000, "R8 start with reserved mode");
        try_blocked(8'b000_0_00_1_1, 3'b100, "R8 start while dma active");
        try_blocked(8'b000_0_01_1_1, 3'b010, "R8 start while receive enabled");
        try_blocked(8'b000_0_10_1_1, 3'b001, "R8 start while transmit pending");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule